// File: doc/BRIEF.md
# Flash Write-Protection Unlock Controller

This block sits between the bus and an on-chip nonvolatile memory space made of three parts: program flash, data EEPROM and option bytes. For every access request it decides at once whether the access may proceed. It raises `acc_grant` or `acc_deny` in the same cycle as the request. Write protection is on after every reset. Software lifts it for each memory class by writing a two-byte key into a key register. A boot-code area at the bottom of program flash stays write-protected against in-application writes even after unlocking.

A read-out protection bit is held in a register. While it is set, it shuts the debug/programming path out of program flash and data EEPROM. Any write that changes this bit produces a one-cycle request to erase all program and data memory. Refused writes set a sticky error flag. Software clears that flag by reading the status register.

The register space is four byte-wide locations, selected by `reg_addr`:
- 0: program key.
- 1: data key.
- 2: status, with bit0 = program unlocked, bit1 = data unlocked, bit2 = write-protection error, bit3 = read-out protection active.
- 3: read-out protection control, where bit0 is the setting.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, and writes are denied to program flash (0x8000–0x9FFF), data EEPROM (0x4000–0x427F) and option bytes (0x4800–0x487F).
- R2: Writing 0x56 and then 0xAE to register 0 sets status bit0. While bit0 is set, in-application writes to program flash outside the boot area are granted.
- R3: A key register write other than 0xAE directly after 0x56 returns the sequence to its start. So does a lone 0xAE. In both cases the flag stays clear.
- R4: The same two-byte key written to register 1 sets status bit1. While bit1 is set, writes to data EEPROM and to option bytes are granted.
- R5: The boot area covers program flash offsets below `boot_pages`×64. In-application writes there are denied even when unlocked. The first address past the area is granted. A value of 128 pages covers the whole 8 KB.
- R6: Writing register 2 with bit0 (or bit1) at 0 clears the matching unlock flag. A 1 in that bit leaves the flag unchanged.
- R7: A denied write sets status bit2. The bit stays set until a read of register 2, which returns it as 1 and then clears it.
- R8: While read-out protection is active (status bit3, register 3 bit0), every debug-path read or write of program flash or data EEPROM is denied.
- R9: A write to register 3 whose bit0 differs from the current setting updates the setting and pulses `erase_req` for exactly one cycle. A write of the same value gives no pulse.
- R10: In-application reads are always granted, and accesses outside the three guarded areas are granted.
- R11: With read-out protection off, debug-path writes to program flash need the program unlock flag but are not subject to the boot area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| boot_pages | input | 8 | Boot area size in 64-byte pages |
| acc_valid | input | 1 | Memory access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_dbg | input | 1 | Request comes over the debug/programming path |
| acc_addr | input | 16 | Access byte address |
| acc_grant | output | 1 | Access allowed |
| acc_deny | output | 1 | Access refused |
| erase_req | output | 1 | One-cycle global erase request |

## Verification
A corrupted sequencer state shows as a flag that sets or stays clear one register write too early or too late. This appears at status bits 0 and 1 on the very next read. A wrong area decode or boot limit flips `acc_grant` within the same cycle as the request, so the bench probes addresses on both sides of each limit. Faults in the error flag or the protection bit appear one cycle after the causing event, on the status read or on `erase_req`.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
   typedef enum logic [1:0] {RGN_OTHER, RGN_PROG, RGN_DATA, RGN_OPT} fwp_region_e;

   localparam logic [1:0] REG_PKEY = 2'd0;
   localparam logic [1:0] REG_DKEY = 2'd1;
   localparam logic [1:0] REG_STAT = 2'd2;
   localparam logic [1:0] REG_ROP  = 2'd3;

   localparam int ST_PUNL  = 0;
   localparam int ST_DUNL  = 1;
   localparam int ST_WPERR = 2;
   localparam int ST_ROP   = 3;
endpackage

// File: rtl/fwp_key_seq.sv
module fwp_key_seq #(
   parameter int unsigned KEY_W = 8,
   parameter logic [KEY_W-1:0] KEY_FIRST = 8'h56,
   parameter logic [KEY_W-1:0] KEY_SECOND = 8'hAE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic [KEY_W-1:0] key_data,
   input  logic             relock,
   output logic             unlocked
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         unlocked <= 1'b0;
      end else begin
         if (key_wr) begin
            if (armed) begin
               armed <= 1'b0;
               if (key_data == KEY_SECOND) unlocked <= 1'b1;
            end else begin
               armed <= (key_data == KEY_FIRST);
            end
         end
         if (relock) unlocked <= 1'b0;
      end
   end

   // R2
   unlock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(key_wr && key_data == KEY_SECOND));

   // R3
   seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && !armed && !unlocked && !relock) |=> !unlocked);
endmodule

// File: rtl/fwp_addr_decode.sv
module fwp_addr_decode
   import fwp_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned BOOT_W     = 8,
   parameter int unsigned PAGE_BYTES = 64,
   parameter int unsigned PROG_BASE  = 32'h8000,
   parameter int unsigned PROG_SIZE  = 8192,
   parameter int unsigned DATA_BASE  = 32'h4000,
   parameter int unsigned DATA_SIZE  = 640,
   parameter int unsigned OPT_BASE   = 32'h4800,
   parameter int unsigned OPT_SIZE   = 128
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BOOT_W-1:0] boot_pages,
   output fwp_region_e       region,
   output logic              boot_hit
);
   localparam int unsigned PROG_END = PROG_BASE + PROG_SIZE;
   localparam int unsigned DATA_END = DATA_BASE + DATA_SIZE;
   localparam int unsigned OPT_END  = OPT_BASE + OPT_SIZE;

   logic [31:0] addr32;
   logic [31:0] boot_lim;
   logic        in_prog, in_data, in_opt;

   always_comb begin
      addr32   = 32'(addr);
      boot_lim = PROG_BASE + 32'(boot_pages) * PAGE_BYTES;
      in_prog  = (addr32 >= PROG_BASE) && (addr32 < PROG_END);
      in_data  = (addr32 >= DATA_BASE) && (addr32 < DATA_END);
      in_opt   = (addr32 >= OPT_BASE)  && (addr32 < OPT_END);
      boot_hit = in_prog && (addr32 < boot_lim);
      if (in_prog)      region = RGN_PROG;
      else if (in_data) region = RGN_DATA;
      else if (in_opt)  region = RGN_OPT;
      else              region = RGN_OTHER;
   end
endmodule

// File: rtl/fwp_rop_ctrl.sv
module fwp_rop_ctrl #(
   parameter logic ROP_INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rop_wr,
   input  logic rop_wval,
   output logic rop_active,
   output logic erase_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rop_active <= ROP_INIT;
         erase_req  <= 1'b0;
      end else begin
         erase_req <= 1'b0;
         if (rop_wr && (rop_wval != rop_active)) begin
            rop_active <= rop_wval;
            erase_req  <= 1'b1;
         end
      end
   end

   // R9
   erase_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rop_active != $past(rop_active)) |-> erase_req);

   // R9
   erase_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> $past(rop_wr));
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
   import fwp_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned PAGE_BYTES  = 64,
   parameter int unsigned PROG_BASE   = 32'h8000,
   parameter int unsigned PROG_SIZE   = 8192,
   parameter int unsigned DATA_BASE   = 32'h4000,
   parameter int unsigned DATA_SIZE   = 640,
   parameter int unsigned OPT_BASE    = 32'h4800,
   parameter int unsigned OPT_SIZE    = 128,
   parameter int unsigned OPT_KEY_SEL = 1,
   parameter logic        ROP_INIT    = 1'b0,
   parameter int unsigned BOOT_W      = $clog2(PROG_SIZE / PAGE_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [BOOT_W-1:0] boot_pages,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              acc_dbg,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              acc_grant,
   output logic              acc_deny,
   output logic              erase_req
);
   localparam int unsigned N_KEYS = 2;

   if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (PROG_SIZE % PAGE_BYTES != 0) begin : g_bad_prog
      $error("PROG_SIZE must be a whole number of pages");
   end
   if (DATA_W < 4) begin : g_bad_dw
      $error("DATA_W too narrow for status");
   end
   if (PROG_BASE + PROG_SIZE > (32'd1 << ADDR_W)) begin : g_bad_map
      $error("program area exceeds address space");
   end

   logic [N_KEYS-1:0] unl;
   logic              opt_unl;
   logic              rop_active;
   logic              wp_err;
   logic              allow;
   fwp_region_e       region;
   logic              boot_hit;

   for (genvar g = 0; g < N_KEYS; g++) begin : g_key
      fwp_key_seq #(.KEY_W(DATA_W)) u_seq (
         .clk      (clk),
         .rst_n    (rst_n),
         .key_wr   (reg_wr && reg_addr == 2'(g)),
         .key_data (reg_wdata),
         .relock   (reg_wr && reg_addr == REG_STAT && !reg_wdata[g]),
         .unlocked (unl[g])
      );
   end

   if (OPT_KEY_SEL == 1) begin : g_opt_data
      assign opt_unl = unl[ST_DUNL];
   end else begin : g_opt_prog
      assign opt_unl = unl[ST_PUNL];
   end

   fwp_addr_decode #(
      .ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .PAGE_BYTES(PAGE_BYTES),
      .PROG_BASE(PROG_BASE), .PROG_SIZE(PROG_SIZE),
      .DATA_BASE(DATA_BASE), .DATA_SIZE(DATA_SIZE),
      .OPT_BASE(OPT_BASE), .OPT_SIZE(OPT_SIZE)
   ) u_dec (
      .addr       (acc_addr),
      .boot_pages (boot_pages),
      .region     (region),
      .boot_hit   (boot_hit)
   );

   fwp_rop_ctrl #(.ROP_INIT(ROP_INIT)) u_rop (
      .clk        (clk),
      .rst_n      (rst_n),
      .rop_wr     (reg_wr && reg_addr == REG_ROP),
      .rop_wval   (reg_wdata[0]),
      .rop_active (rop_active),
      .erase_req  (erase_req)
   );

   always_comb begin
      allow = 1'b1;
      if (acc_dbg && rop_active && (region == RGN_PROG || region == RGN_DATA)) begin
         allow = 1'b0;
      end else if (acc_write) begin
         unique case (region)
            RGN_PROG: allow = unl[ST_PUNL] && (acc_dbg || !boot_hit);
            RGN_DATA: allow = unl[ST_DUNL];
            RGN_OPT:  allow = opt_unl;
            default:  allow = 1'b1;
         endcase
      end
      acc_grant = acc_valid && allow;
      acc_deny  = acc_valid && !allow;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_err <= 1'b0;
      end else if (acc_valid && acc_write && !allow) begin
         wp_err <= 1'b1;
      end else if (reg_rd && reg_addr == REG_STAT) begin
         wp_err <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         REG_STAT: begin
            reg_rdata[ST_PUNL]  = unl[ST_PUNL];
            reg_rdata[ST_DUNL]  = unl[ST_DUNL];
            reg_rdata[ST_WPERR] = wp_err;
            reg_rdata[ST_ROP]   = rop_active;
         end
         REG_ROP: reg_rdata[0] = rop_active;
         default: reg_rdata = '0;
      endcase
   end

   // R5
   boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && !acc_dbg && boot_hit) |-> !acc_grant);

   // R8
   rop_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_dbg && rop_active && (region == RGN_PROG || region == RGN_DATA))
      |-> acc_deny);

   // R7
   wperr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_deny) |=> wp_err);

   // R10
   app_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && !acc_dbg) |-> acc_grant);
endmodule

// File: tb/flash_wp_ctrl_bench.sv
module flash_wp_ctrl_bench;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       reg_wr = 0, reg_rd = 0;
   logic [1:0] reg_addr = 0;
   logic [7:0] reg_wdata = 0;
   logic [7:0] reg_rdata;
   logic [7:0] boot_pages = 0;
   logic       acc_valid = 0, acc_write = 0, acc_dbg = 0;
   logic [15:0] acc_addr = 0;
   logic       acc_grant, acc_deny, erase_req;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   typedef struct {
      bit    exp;
      string tag;
   } item_t;
   item_t sb_q[$];

   always #5 clk = ~clk;

   flash_wp_ctrl u_flash_wp_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .boot_pages(boot_pages), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_dbg(acc_dbg), .acc_addr(acc_addr), .acc_grant(acc_grant),
      .acc_deny(acc_deny), .erase_req(erase_req)
   );

   // monitor: pops expected decisions from the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (acc_valid) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (acc_grant !== it.exp || acc_deny !== !it.exp) begin
               failures++;
               $display("FAIL %s grant=%0b deny=%0b expected grant=%0b",
                        it.tag, acc_grant, acc_deny, it.exp);
            end
         end
      end
   end

   task automatic access(input logic [15:0] a, input bit wr, input bit dbg,
                         input bit exp, input string tag);
      item_t it;
      @(negedge clk);
      acc_valid = 1; acc_addr = a; acc_write = wr; acc_dbg = dbg;
      it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      acc_valid = 0;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      reg_rd = 1; reg_addr = a;
      #3;
      checks++;
      if (reg_rdata !== exp) begin
         failures++;
         $display("FAIL %s rdata=%02h expected=%02h", tag, reg_rdata, exp);
      end
      @(negedge clk);
      reg_rd = 0;
   endtask

   task automatic chk_erase(input bit exp, input string tag);
      #1;
      checks++;
      if (erase_req !== exp) begin
         failures++;
         $display("FAIL %s erase_req=%0b expected=%0b", tag, erase_req, exp);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state and locked areas
      rd_reg(2, 8'h00, "R1 status after reset");
      access(16'h8100, 1, 0, 0, "R1 prog write locked");
      access(16'h4000, 1, 0, 0, "R1 data write locked");
      access(16'h4800, 1, 0, 0, "R1 option write locked");
      // R7 sticky error, clear on read
      rd_reg(2, 8'h04, "R7 error flag set");
      rd_reg(2, 8'h00, "R7 error flag cleared");
      // R3 wrong sequences
      wr_reg(0, 8'h56); wr_reg(0, 8'h00); wr_reg(0, 8'hAE);
      rd_reg(2, 8'h00, "R3 wrong middle value");
      wr_reg(0, 8'hAE); wr_reg(0, 8'h56); wr_reg(0, 8'h56); wr_reg(0, 8'hAE);
      rd_reg(2, 8'h00, "R3 wrong order");
      // R2 correct sequence
      wr_reg(0, 8'h56); wr_reg(0, 8'hAE);
      rd_reg(2, 8'h01, "R2 program unlocked");
      access(16'h8000, 1, 0, 1, "R2 prog write granted");
      // R10 reads and unguarded space
      access(16'h8000, 0, 0, 1, "R10 app read");
      access(16'h1000, 1, 0, 1, "R10 unguarded write");
      // R5 boot area
      boot_pages = 8'd4;
      access(16'h80FF, 1, 0, 0, "R5 last boot byte");
      access(16'h8100, 1, 0, 1, "R5 first byte past boot");
      access(16'h8000, 1, 1, 1, "R11 debug write in boot");
      boot_pages = 8'd128;
      access(16'h9FFF, 1, 0, 0, "R5 full boot area");
      boot_pages = 8'd0;
      // R4 data key
      access(16'h427F, 1, 0, 0, "R4 data locked");
      wr_reg(1, 8'h56); wr_reg(1, 8'hAE);
      rd_reg(2, 8'h07, "R4 data unlocked with error");
      rd_reg(2, 8'h03, "R7 error cleared");
      access(16'h427F, 1, 0, 1, "R4 data write granted");
      access(16'h4800, 1, 0, 1, "R4 option write granted");
      // R6 relock
      wr_reg(2, 8'hFF);
      rd_reg(2, 8'h03, "R6 ones keep flags");
      wr_reg(2, 8'h02);
      rd_reg(2, 8'h02, "R6 program relocked");
      access(16'h8100, 1, 0, 0, "R6 prog write after relock");
      access(16'h8100, 1, 1, 0, "R11 debug write needs key");
      rd_reg(2, 8'h06, "R7 set by relocked write");
      // R8 R9 read-out protection
      wr_reg(3, 8'h01);
      chk_erase(1, "R9 erase pulse on enable");
      @(negedge clk);
      chk_erase(0, "R9 erase pulse one cycle");
      rd_reg(2, 8'h0A, "R8 protection in status");
      access(16'h8000, 0, 1, 0, "R8 debug prog read blocked");
      access(16'h4000, 1, 1, 0, "R8 debug data write blocked");
      access(16'h1000, 0, 1, 1, "R8 debug read elsewhere");
      access(16'h8000, 0, 0, 1, "R10 app read under protection");
      wr_reg(3, 8'h01);
      chk_erase(0, "R9 no erase on same value");
      wr_reg(3, 8'h00);
      chk_erase(1, "R9 erase pulse on disable");
      rd_reg(3, 8'h00, "R9 protection off");
      access(16'h8000, 0, 1, 1, "R8 debug read after disable");
      repeat (3) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule